// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps a small cache of page table entries, keyed by virtual page number, next to the address path. A requester gives a virtual page number and gets two answers in the same cycle: whether a copy of the entry is held, and the entry itself. When there is no copy, an external table walker fetches the entry from memory. It then writes the page number and entry pair in through the fill port.

The page number is split into two fields. The low bits choose one set. The upper bits are the tag, which is compared against every way of that set. A fill goes to a free way of its set first. If the set is full, a round-robin pointer kept for each set chooses the victim. A fill for a page that is already held overwrites the entry in place. A flush input drops every entry at once, for example when the address space changes.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid: every lookup misses and `lk_pte` reads zero.
- R2: Bits `[SET_BITS-1:0]` of the page number select the set, and the remaining upper bits are the tag. Two pages with the same tag but different set bits are held independently.
- R3: A lookup hits in the same cycle when a valid way of the selected set holds a matching tag. `lk_pte` then carries that way's entry. On a miss `lk_pte` is zero.
- R4: A fill becomes visible to lookups from the cycle after `fill_en`. A lookup in the fill cycle itself sees the previous contents.
- R5: A fill into a set that has a free way takes the lowest-numbered free way and evicts nothing.
- R6: A fill into a full set replaces the way named by that set's pointer, and the pointer then steps to the next way, wrapping after the last. Each pointer starts at way 0 after reset.
- R7: A fill whose page is already held in the set overwrites that way's entry. It creates no second copy and does not move the pointer.
- R8: `flush` invalidates every entry in one cycle. A lookup during the flush cycle misses. A fill in the flush cycle is dropped.
- R9: With `lk_valid` low, `lk_hit` stays low whatever the page number.
- R10: Replacement pointers are kept per set, so a replacement in one set does not change the victim choice of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_pte | output | PTE_W | Entry for a hit, zero otherwise |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number of the entry being installed |
| fill_pte | input | PTE_W | Page table entry being installed |

## Verification
The lookup path is tried with four kinds of page number: an exact match, one that differs only in its set bits, one that differs only in its tag, and the largest possible value. These separate a wrong split of the index field from a wrong tag compare. Fill sequences run in three orders. Filling a set from empty tells free-way placement apart from eviction. Filling past capacity shows the round-robin order. Re-filling a page that is already held shows whether the pointer moves wrongly, because the next eviction then takes a different entry. A second set is filled while the first set's pointer is not at way 0, which exposes a pointer shared between sets.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // Width of an index that selects one of n items; at least one bit.
   function automatic int unsigned sel_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned TAG_W = 18
) (
   input  logic [WAYS-1:0]             line_ok,
   input  logic [WAYS-1:0][TAG_W-1:0]  line_tag,
   input  logic [TAG_W-1:0]            probe_tag,
   output logic [WAYS-1:0]             match
);
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign match[w] = line_ok[w] && (line_tag[w] == probe_tag);
      end
   endgenerate
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned PTR_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [WAYS-1:0]  line_ok,
   input  logic [WAYS-1:0]  match,
   input  logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] way,
   output logic             advance
);
   logic found;

   always_comb begin
      way     = ptr;
      advance = 1'b0;
      found   = 1'b0;
      // An existing copy takes precedence: overwrite in place.
      for (int w = 0; w < WAYS; w++) begin
         if (!found && match[w]) begin
            way   = PTR_W'(w);
            found = 1'b1;
         end
      end
      // Next choice: the lowest free way.
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !line_ok[w]) begin
            way   = PTR_W'(w);
            found = 1'b1;
         end
      end
      // Set is full: evict the pointed way.
      if (!found) advance = 1'b1;
   end

   // R6: the pointer moves only when the set is full and no way matches
   assert_evict_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && advance) |-> (&line_ok && !(|match)));
   // R6: the chosen way is a real way
   assert_way_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (int'(way) < WAYS));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int unsigned VPN_W    = 20,
   parameter int unsigned PTE_W    = 32,
   parameter int unsigned SET_BITS = 2,
   parameter int unsigned WAYS     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PTE_W-1:0] lk_pte,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PTE_W-1:0] fill_pte
);
   localparam int unsigned SETS  = 1 << SET_BITS;
   localparam int unsigned TAG_W = VPN_W - SET_BITS;
   localparam int unsigned PTR_W = xlat_pkg::sel_w(WAYS);

   generate
      if (SET_BITS < 1)        begin : g_bad_sets  $error("SET_BITS must be at least 1"); end
      if (SET_BITS >= VPN_W)   begin : g_bad_tag   $error("tag field would be empty"); end
      if (WAYS < 1)            begin : g_bad_ways  $error("WAYS must be at least 1"); end
      if (SETS * WAYS > 4096)  begin : g_too_big   $error("too many lines for a lookaside buffer"); end
   endgenerate

   logic [SETS-1:0][WAYS-1:0]             ok_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][PTE_W-1:0]  pte_q;
   logic [SETS-1:0][PTR_W-1:0]            rr_q;

   logic [SET_BITS-1:0] lk_set, fill_set;
   logic [TAG_W-1:0]    lk_tag, fill_tag;
   logic [WAYS-1:0]     lk_match, fill_match;
   logic [PTR_W-1:0]    fill_way;
   logic                fill_adv, fill_go;

   assign lk_set   = lk_vpn[SET_BITS-1:0];
   assign lk_tag   = lk_vpn[VPN_W-1:SET_BITS];
   assign fill_set = fill_vpn[SET_BITS-1:0];
   assign fill_tag = fill_vpn[VPN_W-1:SET_BITS];
   assign fill_go  = fill_en && !flush;

   xlat_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
      .line_ok(ok_q[lk_set]), .line_tag(tag_q[lk_set]),
      .probe_tag(lk_tag), .match(lk_match));

   xlat_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_cmp (
      .line_ok(ok_q[fill_set]), .line_tag(tag_q[fill_set]),
      .probe_tag(fill_tag), .match(fill_match));

   xlat_victim_pick #(.WAYS(WAYS), .PTR_W(PTR_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(fill_go),
      .line_ok(ok_q[fill_set]), .match(fill_match), .ptr(rr_q[fill_set]),
      .way(fill_way), .advance(fill_adv));

   // Lookup: combinational, gated by request and flush.
   always_comb begin
      lk_pte = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_match[w]) lk_pte = lk_pte | pte_q[lk_set][w];
      end
      if (!lk_valid || flush) lk_pte = '0;
   end
   assign lk_hit = lk_valid && !flush && (|lk_match);

   // Valid bits and replacement pointers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q <= '0;
         rr_q <= '0;
      end else if (flush) begin
         ok_q <= '0;
      end else if (fill_en) begin
         ok_q[fill_set][fill_way] <= 1'b1;
         if (fill_adv) begin
            if (rr_q[fill_set] == PTR_W'(WAYS - 1)) rr_q[fill_set] <= '0;
            else                                     rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
         end
      end
   end

   // Line payload needs no reset: it is qualified by the valid bits.
   always_ff @(posedge clk) begin
      if (fill_go) begin
         tag_q[fill_set][fill_way] <= fill_tag;
         pte_q[fill_set][fill_way] <= fill_pte;
      end
   end

   // R7: never two matching ways for one page
   assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot0(lk_match));
   // R8: everything is invalid right after a flush
   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ok_q == '0));
   // R4: an accepted fill leaves at least one valid line
   assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |=> (ok_q != '0));
   // R3: a hit always returns the entry of exactly one way
   assert_hit_one_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> $countones(lk_match) == 1);
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic        lk_hit;
   logic [31:0] lk_pte;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [31:0] fill_pte = '0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   xlat_cache u_xlat_cache (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pte(lk_pte),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte));

   typedef struct packed {
      logic        fill;
      logic [19:0] vpn;
      logic [31:0] pte;
      logic        hit;
      logic [3:0]  req;
   } step_t;

   // page = tag<<2 | set; sets 1 and 2 both hold 2 ways.
   localparam int NSTEP = 31;
   localparam step_t STEPS [NSTEP] = '{
      '{1'b0, 20'h00015, 32'h0,        1'b0, 4'd1},  // R1 empty
      '{1'b1, 20'h00015, 32'hA0000001, 1'b0, 4'd3},  // A -> set1 way0
      '{1'b0, 20'h00015, 32'hA0000001, 1'b1, 4'd3},  // R3 hit A
      '{1'b0, 20'h00016, 32'h0,        1'b0, 4'd2},  // R2 same tag other set
      '{1'b0, 20'h00019, 32'h0,        1'b0, 4'd3},  // other tag misses
      '{1'b1, 20'h00019, 32'hB0000002, 1'b0, 4'd5},  // B -> free way1
      '{1'b0, 20'h00015, 32'hA0000001, 1'b1, 4'd5},  // R5 A not evicted
      '{1'b0, 20'h00019, 32'hB0000002, 1'b1, 4'd5},
      '{1'b1, 20'h0001D, 32'hC0000003, 1'b0, 4'd6},  // C evicts way0 (A)
      '{1'b0, 20'h00015, 32'h0,        1'b0, 4'd6},  // R6 A gone
      '{1'b0, 20'h00019, 32'hB0000002, 1'b1, 4'd6},
      '{1'b0, 20'h0001D, 32'hC0000003, 1'b1, 4'd6},
      '{1'b1, 20'h00021, 32'hD0000004, 1'b0, 4'd6},  // D evicts way1 (B)
      '{1'b0, 20'h00019, 32'h0,        1'b0, 4'd6},
      '{1'b0, 20'h00021, 32'hD0000004, 1'b1, 4'd6},
      '{1'b1, 20'h0001D, 32'hC0C0C0C0, 1'b0, 4'd7},  // refill C in place
      '{1'b0, 20'h0001D, 32'hC0C0C0C0, 1'b1, 4'd7},  // R7 new entry
      '{1'b1, 20'h00025, 32'hE0000005, 1'b0, 4'd7},  // E: pointer still way0
      '{1'b0, 20'h00021, 32'hD0000004, 1'b1, 4'd7},  // D kept
      '{1'b0, 20'h0001D, 32'h0,        1'b0, 4'd7},  // C evicted
      '{1'b1, 20'h00016, 32'hF0000006, 1'b0, 4'd2},  // F -> set2 way0
      '{1'b0, 20'h00016, 32'hF0000006, 1'b1, 4'd2},
      '{1'b0, 20'h00015, 32'h0,        1'b0, 4'd2},
      '{1'b1, 20'h0000E, 32'h11000007, 1'b0, 4'd10}, // G -> set2 way1
      '{1'b1, 20'h00012, 32'h12000008, 1'b0, 4'd10}, // H evicts set2 way0
      '{1'b0, 20'h00016, 32'h0,        1'b0, 4'd10}, // R10 F gone
      '{1'b0, 20'h0000E, 32'h11000007, 1'b1, 4'd10}, // G kept
      '{1'b0, 20'h00012, 32'h12000008, 1'b1, 4'd10},
      '{1'b1, 20'hFFFFF, 32'hFFFF0009, 1'b0, 4'd2},  // largest page
      '{1'b0, 20'hFFFFF, 32'hFFFF0009, 1'b1, 4'd2},
      '{1'b0, 20'hFFFFE, 32'h0,        1'b0, 4'd2}
   };

   task automatic check(input string req, input logic hit_exp, input logic [31:0] pte_exp);
      checks++;
      if (lk_hit !== hit_exp || lk_pte !== pte_exp) begin
         fails++;
         $display("FAIL %s: hit=%0b pte=%h expected hit=%0b pte=%h",
                  req, lk_hit, lk_pte, hit_exp, pte_exp);
      end
   endtask

   task automatic idle();
      lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b0;
   endtask

   task automatic do_fill(input logic [19:0] v, input logic [31:0] p);
      @(negedge clk);
      idle(); fill_en = 1'b1; fill_vpn = v; fill_pte = p;
   endtask

   task automatic do_look(input logic [19:0] v, input string req,
                          input logic hit_exp, input logic [31:0] pte_exp);
      @(negedge clk);
      idle(); lk_valid = 1'b1; lk_vpn = v;
      #1 check(req, hit_exp, pte_exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      do_look(20'h00000, "R1", 1'b0, 32'h0);
      do_look(20'h00015, "R1", 1'b0, 32'h0);

      for (int i = 0; i < NSTEP; i++) begin
         if (STEPS[i].fill) do_fill(STEPS[i].vpn, STEPS[i].pte);
         else do_look(STEPS[i].vpn, $sformatf("R%0d", STEPS[i].req),
                      STEPS[i].hit, STEPS[i].pte);
      end

      // R9: idle lookup of a held page reports no hit
      @(negedge clk);
      idle(); lk_vpn = 20'h00021;
      #1 check("R9", 1'b0, 32'h0);

      // R4: same-cycle fill and lookup sees old contents
      @(negedge clk);
      idle(); fill_en = 1'b1; fill_vpn = 20'h00033; fill_pte = 32'h33000033;
      lk_valid = 1'b1; lk_vpn = 20'h00033;
      #1 check("R4", 1'b0, 32'h0);
      do_look(20'h00033, "R4", 1'b1, 32'h33000033);

      // R8: lookup during flush misses, fill in flush cycle is dropped
      @(negedge clk);
      idle(); flush = 1'b1; lk_valid = 1'b1; lk_vpn = 20'h00021;
      fill_en = 1'b1; fill_vpn = 20'h00037; fill_pte = 32'h37000037;
      #1 check("R8", 1'b0, 32'h0);
      do_look(20'h00021, "R8", 1'b0, 32'h0);
      do_look(20'h00037, "R8", 1'b0, 32'h0);
      do_look(20'hFFFFF, "R8", 1'b0, 32'h0);

      @(negedge clk);
      idle();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2000000;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule